// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out for the Register Operand

This block sits on the register-operand path of a data-processing datapath. It takes one 32-bit register value and applies one of five operations to it: a left shift, a logical right shift, an arithmetic right shift, a rotate right, or a one-bit rotate right through the carry flag. It also produces the shifter carry, which is the last bit moved out of the word.

Each operation accepts only its own legal range of amounts. If the amount or the operation code is illegal, an error flag is raised, the operand passes through unchanged, and the carry keeps its incoming value. The result, the carry and the error flag are all registered. They appear one clock after a cycle in which the input strobe is high, together with a registered valid.

Top module: `opShifter`

## Requirements
- R1: Operation code 0 is a left shift. Amounts 1 to 31 move the operand left and fill with zeros, and the carry is operand bit 32−n. An amount of 0 gives the operand unchanged with the carry equal to the input carry.
- R2: Operation code 1 is a logical right shift. It accepts amounts 1 to 32 and fills with zeros. The carry is operand bit n−1, so an amount of 32 gives a zero result and a carry equal to operand bit 31.
- R3: Operation code 2 is an arithmetic right shift. It accepts amounts 1 to 32 and fills with copies of operand bit 31. The carry is operand bit n−1, so an amount of 32 makes every result bit and the carry equal to operand bit 31.
- R4: Operation code 3 is a rotate right. It accepts amounts 1 to 31. The bits that leave at the bottom re-enter at the top, and the carry equals bit 31 of the result.
- R5: Operation code 4 is a rotate right by one through the carry. The result is {input carry, operand[31:1]}, the carry is operand bit 0, and the amount input is ignored.
- R6: An illegal amount for the chosen operation, or an operation code of 5 to 7, sets the error output. The result is then the operand unchanged and the carry is the input carry. A legal request clears the error output.
- R7: The result, carry and error output appear exactly one clock after a cycle with the input strobe high, and the valid output is high in that cycle only. When the strobe is low, the valid output falls and the result and carry outputs hold their last values.
- R8: A synchronous reset clears the valid output, even while the input strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input strobe |
| inData | input | 32 | Register operand |
| inKind | input | 3 | Operation code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry) |
| inAmount | input | 6 | Shift amount |
| inCarry | input | 1 | Current carry flag |
| outValid | output | 1 | Registered valid |
| outData | output | 32 | Shifted operand |
| outCarry | output | 1 | Shifter carry-out |
| outError | output | 1 | Illegal amount or operation code |

## Verification
The following behaviours are checked by assertions on every cycle:
- the one-cycle valid relation and the hold of the outputs while idle;
- pass-through of the operand and carry whenever the error flag is set;
- the identity of a zero-amount left shift;
- the rotate-through-carry result;
- the 32-bit logical right shift and the sign fill of the arithmetic right shift.

Other behaviours only the bench scenarios can show:
- exact carry bit positions for intermediate amounts;
- the rotate wrap-around;
- the edges of each legal range (0, 1, 31, 32 and 33);
- reset taking priority over a live strobe.

The bench compares every result against a bit-by-bit model.

// File: rtl/opShiftPkg.sv
package opShiftPkg;

  typedef enum logic [2:0] {
    KIND_LSL = 3'd0,
    KIND_LSR = 3'd1,
    KIND_ASR = 3'd2,
    KIND_ROR = 3'd3,
    KIND_RRX = 3'd4
  } shiftKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;    // capture a new result this cycle
    logic       bypass;  // pass operand and carry through unchanged
    shiftKind_e kind;    // decoded operation (valid when !bypass)
  } shiftStrobe_t;

endpackage

// File: rtl/opShiftCtrl.sv
module opShiftCtrl
  import opShiftPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [2:0]       inKind,
  input  logic [AMT_W-1:0] inAmount,
  output shiftStrobe_t     strobe,
  output logic             validQ,
  output logic             errorQ
);

  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(WIDTH);
  localparam logic [AMT_W-1:0] AMT_TOP  = AMT_W'(WIDTH - 1);

  logic legal;
  logic amtZero;

  assign amtZero = (inAmount == '0);

  always_comb begin
    case (inKind)
      3'd0:    legal = (inAmount <= AMT_TOP);
      3'd1,
      3'd2:    legal = !amtZero && (inAmount <= AMT_FULL);
      3'd3:    legal = !amtZero && (inAmount <= AMT_TOP);
      3'd4:    legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    strobe.load   = inValid;
    strobe.bypass = !legal || ((inKind == 3'd0) && amtZero);
    strobe.kind   = legal ? shiftKind_e'(inKind) : KIND_LSL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
      errorQ <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid) errorQ <= !legal;
    end
  end

endmodule

// File: rtl/opShiftDatapath.sv
module opShiftDatapath
  import opShiftPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  shiftStrobe_t     strobe,
  input  logic [WIDTH-1:0] inData,
  input  logic [AMT_W-1:0] inAmount,
  input  logic             inCarry,
  output logic [WIDTH-1:0] dataQ,
  output logic             carryQ
);

  localparam logic [WIDTH-1:0] ONE_HOT0 = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(WIDTH);

  logic [AMT_W-1:0] amtMinus1;
  logic [WIDTH:0]   leftWide;
  logic [WIDTH-1:0] lsrRes;
  logic [WIDTH-1:0] asrRes;
  logic [WIDTH-1:0] rorRes;
  logic [WIDTH-1:0] rrxRes;
  logic             rightCarry;
  logic [WIDTH-1:0] nextData;
  logic             nextCarry;

  assign amtMinus1  = inAmount - AMT_W'(1);
  assign leftWide   = {1'b0, inData} << inAmount;
  assign lsrRes     = inData >> inAmount;
  assign asrRes     = $unsigned($signed(inData) >>> inAmount);
  assign rorRes     = (inData >> inAmount) | (inData << (AMT_FULL - inAmount));
  assign rrxRes     = {inCarry, inData[WIDTH-1:1]};
  // last bit leaving at the bottom for right shifts by 1..WIDTH
  assign rightCarry = |(inData & (ONE_HOT0 << amtMinus1));

  always_comb begin
    nextData  = inData;
    nextCarry = inCarry;
    if (!strobe.bypass) begin
      case (strobe.kind)
        KIND_LSL: begin
          nextData  = leftWide[WIDTH-1:0];
          nextCarry = leftWide[WIDTH];
        end
        KIND_LSR: begin
          nextData  = lsrRes;
          nextCarry = rightCarry;
        end
        KIND_ASR: begin
          nextData  = asrRes;
          nextCarry = rightCarry;
        end
        KIND_ROR: begin
          nextData  = rorRes;
          nextCarry = rorRes[WIDTH-1];
        end
        KIND_RRX: begin
          nextData  = rrxRes;
          nextCarry = inData[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ  <= '0;
      carryQ <= 1'b0;
    end else if (strobe.load) begin
      dataQ  <= nextData;
      carryQ <= nextCarry;
    end
  end

endmodule

// File: rtl/opShifter.sv
module opShifter
  import opShiftPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  input  logic [2:0]       inKind,
  input  logic [AMT_W-1:0] inAmount,
  input  logic             inCarry,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic             outCarry,
  output logic             outError
);

  shiftStrobe_t strobe;

  opShiftCtrl #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inKind   (inKind),
    .inAmount (inAmount),
    .strobe   (strobe),
    .validQ   (outValid),
    .errorQ   (outError)
  );

  opShiftDatapath #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inData   (inData),
    .inAmount (inAmount),
    .inCarry  (inCarry),
    .dataQ    (outData),
    .carryQ   (outCarry)
  );

endmodule

// File: rtl/opShifterChecker.sv
module opShifterChecker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [31:0] inData,
  input logic [2:0]  inKind,
  input logic [5:0]  inAmount,
  input logic        inCarry,
  input logic        outValid,
  input logic [31:0] outData,
  input logic        outCarry,
  input logic        outError
);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);  // R7
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);  // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(outData) && $stable(outCarry)));  // R7
  AST_ERR_PASS: assert property (@(posedge clk) disable iff (rst)
    (inValid && (inKind > 3'd4)) |=>
      (outError && outData == $past(inData) && outCarry == $past(inCarry)));  // R6
  AST_LSL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inValid && inKind == 3'd0 && inAmount == 6'd0) |=>
      (!outError && outData == $past(inData) && outCarry == $past(inCarry)));  // R1
  AST_LSR_FULL: assert property (@(posedge clk) disable iff (rst)
    (inValid && inKind == 3'd1 && inAmount == 6'd32) |=>
      (outData == 32'd0 && outCarry == $past(inData[31])));  // R2
  AST_ASR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (inValid && inKind == 3'd2 && inAmount != 6'd0 && inAmount <= 6'd32) |=>
      (outData[31] == $past(inData[31])));  // R3
  AST_ROR_CARRY: assert property (@(posedge clk) disable iff (rst)
    (inValid && inKind == 3'd3 && inAmount != 6'd0 && inAmount < 6'd32) |=>
      (outCarry == outData[31]));  // R4
  AST_RRX_FORM: assert property (@(posedge clk) disable iff (rst)
    (inValid && inKind == 3'd4) |=>
      (outData == {$past(inCarry), $past(inData[31:1])} &&
       outCarry == $past(inData[0]) && !outError));  // R5

endmodule

bind opShifter opShifterChecker u_opShifterChecker (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inData   (inData),
  .inKind   (inKind),
  .inAmount (inAmount),
  .inCarry  (inCarry),
  .outValid (outValid),
  .outData  (outData),
  .outCarry (outCarry),
  .outError (outError)
);

// File: tb/opShifter_bench.sv
`timescale 1ns/1ps
module opShifter_bench;

  localparam real CLK_HALF = 10.0;  // 50 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [2:0]  inKind = '0;
  logic [5:0]  inAmount = '0;
  logic        inCarry = 1'b0;
  logic        outValid;
  logic [31:0] outData;
  logic        outCarry;
  logic        outError;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [31:0] d;
    logic        c;
    logic        e;
    logic [7:0]  req;
  } expItem_t;

  expItem_t expQ[$];
  logic [31:0] lastData;
  logic        lastCarry;

  always #(CLK_HALF) clk = ~clk;

  opShifter u_opShifter (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inKind(inKind),
    .inAmount(inAmount), .inCarry(inCarry), .outValid(outValid), .outData(outData),
    .outCarry(outCarry), .outError(outError)
  );

  // Reference model, bit by bit, built from the requirements
  function automatic void model(input logic [31:0] d, input logic [2:0] k,
                                input logic [5:0] a, input logic c,
                                output logic [31:0] rd, output logic rc, output logic re);
    logic ok;
    case (k)
      3'd0: ok = (a <= 6'd31);
      3'd1, 3'd2: ok = (a >= 6'd1 && a <= 6'd32);
      3'd3: ok = (a >= 6'd1 && a <= 6'd31);
      3'd4: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    rd = d; rc = c; re = !ok;
    if (ok) begin
      if (k == 3'd4) begin
        rc = d[0]; rd = {c, d[31:1]};
      end else begin
        for (int i = 0; i < int'(a); i++) begin
          case (k)
            3'd0: begin rc = rd[31]; rd = {rd[30:0], 1'b0}; end
            3'd1: begin rc = rd[0];  rd = {1'b0, rd[31:1]}; end
            3'd2: begin rc = rd[0];  rd = {rd[31], rd[31:1]}; end
            default: begin rc = rd[0]; rd = {rd[0], rd[31:1]}; end
          endcase
        end
      end
    end
  endfunction

  task automatic sendOp(input logic [31:0] d, input logic [2:0] k, input logic [5:0] a,
                        input logic c, input logic [7:0] req);
    expItem_t it;
    logic [31:0] rd; logic rc, re;
    model(d, k, a, c, rd, rc, re);
    @(negedge clk);
    inValid = 1'b1; inData = d; inKind = k; inAmount = a; inCarry = c;
    it.d = rd; it.c = rc; it.e = re; it.req = req;
    expQ.push_back(it);
    lastData = rd; lastCarry = rc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData = ~inData; inKind = 3'd1; inAmount = 6'd5; inCarry = ~inCarry;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (!rst && outValid && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected valid", 32'd1, 32'd0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(outData == it.d && outCarry == it.c && outError == it.e,
              $sformatf("R%0d", it.req), "data/carry/error",
              outData ^ {outCarry, outError, 30'd0}, it.d ^ {it.c, it.e, 30'd0});
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", expQ.size());
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    #1 check(outValid == 1'b0, "R8", "valid in reset", {31'd0, outValid}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R1 left shift
    sendOp(32'h8000_0001, 3'd0, 6'd0, 1'b1, 8'd1);
    sendOp(32'h8000_0001, 3'd0, 6'd1, 1'b0, 8'd1);
    sendOp(32'h0000_0003, 3'd0, 6'd31, 1'b0, 8'd1);
    sendOp(32'h0F00_000F, 3'd0, 6'd4, 1'b1, 8'd1);
    // R2 logical right
    sendOp(32'h0000_0003, 3'd1, 6'd1, 1'b0, 8'd2);
    sendOp(32'h8000_0000, 3'd1, 6'd32, 1'b0, 8'd2);
    sendOp(32'hABCD_8123, 3'd1, 6'd16, 1'b0, 8'd2);
    // R3 arithmetic right
    sendOp(32'h8000_0001, 3'd2, 6'd32, 1'b0, 8'd3);
    sendOp(32'hF000_0018, 3'd2, 6'd4, 1'b0, 8'd3);
    sendOp(32'h4000_0001, 3'd2, 6'd1, 1'b0, 8'd3);
    // R4 rotate
    sendOp(32'h1234_5678, 3'd3, 6'd8, 1'b0, 8'd4);
    sendOp(32'h8000_0001, 3'd3, 6'd31, 1'b0, 8'd4);
    sendOp(32'h0000_0001, 3'd3, 6'd1, 1'b0, 8'd4);
    // R5 rotate through carry, amount ignored
    sendOp(32'h0000_0002, 3'd4, 6'd1, 1'b1, 8'd5);
    sendOp(32'h0000_0001, 3'd4, 6'd45, 1'b0, 8'd5);
    // R6 illegal requests
    sendOp(32'hDEAD_BEEF, 3'd0, 6'd32, 1'b1, 8'd6);
    sendOp(32'hDEAD_BEEF, 3'd1, 6'd0, 1'b0, 8'd6);
    sendOp(32'hDEAD_BEEF, 3'd1, 6'd33, 1'b1, 8'd6);
    sendOp(32'hDEAD_BEEF, 3'd3, 6'd32, 1'b0, 8'd6);
    sendOp(32'hDEAD_BEEF, 3'd3, 6'd0, 1'b1, 8'd6);
    sendOp(32'hDEAD_BEEF, 3'd2, 6'd63, 1'b0, 8'd6);
    sendOp(32'hDEAD_BEEF, 3'd5, 6'd3, 1'b1, 8'd6);
    sendOp(32'hDEAD_BEEF, 3'd7, 6'd1, 1'b0, 8'd6);
    sendOp(32'h0000_0010, 3'd1, 6'd4, 1'b0, 8'd6);  // error clears

    // R7 hold while idle
    idle(3);
    #1 check(outValid == 1'b0 && outData == lastData && outCarry == lastCarry,
             "R7", "hold while idle", outData, lastData);

    // mixed pseudo-random stream, back to back (R1..R6)
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sendOp(lfsr ^ {lfsr[15:0], lfsr[31:16]}, 3'(lfsr[2:0] % 3'd6), lfsr[13:8],
             lfsr[20], 8'd7);
      if (n % 37 == 0) idle(1);
    end
    idle(2);

    // R8 reset overrides strobe
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1;
    @(negedge clk);
    #1 check(outValid == 1'b0, "R8", "valid under reset", {31'd0, outValid}, 32'd0);
    inValid = 1'b0;
    @(negedge clk); rst = 1'b0;
    idle(2);
    #1 check(expQ.size() == 0, "R7", "all results seen", expQ.size(), 32'd0);
    summary();
  end

endmodule